// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches 23 external input lines and turns chosen signal edges into latched interrupt requests. Every line first crosses into the block's clock through a two-flop synchroniser. A rising or falling transition is then detected by comparing the synchronised level with its value one clock earlier. Each line can be armed for rising edges, for falling edges, or for both. A detected edge sets a sticky pending flag that stays set until software clears it. Software can also set a flag directly through a trigger register.

Pending flags that are unmasked drive a reduced set of 12 level interrupt outputs. Lines 0 to 4 each have their own output. Lines 5 to 9 share one output and lines 10 to 15 share another. Lines 16, 17, 18, 21 and 22 each have their own output. Lines 19 and 20 reach no output. A separate event mask produces a one-cycle pulse per line on each detected edge, for logic that wants a strobe rather than a held request.

Software reaches the block through a plain 32-bit register bus with write strobe, read strobe, byte address and data. Line n always occupies bit n of every register.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and all `irq_out` and `evt_out` bits are 0.
- R2: Registers sit at byte offsets 0x00 interrupt mask, 0x04 event mask, 0x08 rising select, 0x0C falling select, 0x10 software trigger, 0x14 pending, with line n at bit n. Bits 31:23 read 0. A read at any other address returns 0, and `bus_rdata` is 0 while `bus_rd` is low.
- R3: A level change on `ext_in` that is applied between clock edges shows in the pending register after the third following rising clock edge, and not before.
- R4: The rising-select and falling-select bits act independently. An edge of a direction that is not selected leaves pending unchanged. With both bits set, either edge sets pending.
- R5: Writing the pending register clears exactly the lines whose data bits are 1. Zero bits leave their flags unchanged.
- R6: When an edge is detected for a line in the same cycle as a clear write to that line, the pending bit ends up set.
- R7: Writing 1 to a software trigger bit sets that line's trigger bit and its pending bit. A trigger bit is cleared by the clear write that clears its pending bit. Writing 0 to the trigger register changes nothing.
- R8: A pending bit latches whether or not its interrupt mask bit is set. An interrupt output is high only while at least one of its lines has both pending and mask bits set.
- R9: Output mapping: `irq_out[0..4]` = lines 0..4; `irq_out[5]` = OR of lines 5..9; `irq_out[6]` = OR of lines 10..15; `irq_out[7..9]` = lines 16..18; `irq_out[10]` = line 21; `irq_out[11]` = line 22.
- R10: Lines 19 and 20 latch pending normally but never drive any `irq_out` bit.
- R11: `evt_out[n]` pulses high for one cycle, in the same cycle that pending would be set, for each detected edge on line n whose event mask bit is 1. The event mask has no effect on pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 23 | Asynchronous external lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 12 | Level interrupt requests, grouped as in R9 |
| evt_out | output | 23 | One-cycle event pulses per line |

## Verification
The two functions that can meet in one cycle are a newly detected edge and a software clear of the same pending bit. The bench raises a line and then times the clear write so that it is sampled on the very edge where the synchronised transition is detected. It then reads pending back and expects the bit to still be set. A reference model in the bench steps through the same race cycle by cycle and judges every output on every clock, so an inverted priority is caught both by the directed read and by the running comparison.

// File: rtl/edge_irq_pkg.sv
// Package: shared sizes, register indices and the line-to-output grouping
// for the external edge interrupt controller.
// Assumes: the grouping is fixed by the product and is not a parameter.
package edge_irq_pkg;

    localparam int NUM_LINES = 23;
    localparam int NUM_IRQ   = 12;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int NUM_REGS  = 6;

    // Word index of each register, byte offset = index * 4
    typedef enum logic [2:0] {
        REG_IMASK  = 3'd0,
        REG_EMASK  = 3'd1,
        REG_RISE   = 3'd2,
        REG_FALL   = 3'd3,
        REG_SWTRIG = 3'd4,
        REG_PEND   = 3'd5
    } reg_sel_e;

    // Output index driven by a line, or -1 when the line has no output
    function automatic int irq_of_line(input int ln);
        if (ln <= 4)                    return ln;
        else if (ln <= 9)               return 5;
        else if (ln <= 15)              return 6;
        else if (ln <= 18)              return ln - 9;
        else if (ln == 21)              return 10;
        else if (ln == 22)              return 11;
        else                            return -1;
    endfunction

endpackage

// File: rtl/edge_irq_sync.sv
// Module: edge_irq_sync
// Brings the asynchronous lines into the clock domain with two flops each,
// keeps one further delayed copy, and flags selected rising/falling edges.
// Assumes: each input level is held for at least two clocks to be seen.
module edge_irq_sync #(
    parameter int N = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ext_in,
    input  logic [N-1:0] rise_sel,
    input  logic [N-1:0] fall_sel,
    output logic [N-1:0] edge_hit
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    // Two-stage synchroniser plus one-cycle history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= ext_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Qualified edge: a direction counts only when its select bit is set
    always_comb begin
        edge_hit = (sync_q & ~prev_q & rise_sel) | (~sync_q & prev_q & fall_sel);
    end

endmodule

// File: rtl/edge_irq_regs.sv
// Module: edge_irq_regs
// Register file: masks, edge selects, software trigger, sticky pending
// with write-one-to-clear, and the registered event pulse.
// Assumes: word-aligned accesses; a misaligned or unmapped access is ignored.
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int N  = NUM_LINES,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  edge_hit,
    output logic [N-1:0]  imask,
    output logic [N-1:0]  emask,
    output logic [N-1:0]  rise_sel,
    output logic [N-1:0]  fall_sel,
    output logic [N-1:0]  sw_bits,
    output logic [N-1:0]  pend,
    output logic [N-1:0]  evt_out
);

    localparam int IDX_W = AW - 2;

    logic [IDX_W-1:0]    idx;
    logic                aligned;
    logic [NUM_REGS-1:0] wsel;
    logic [N-1:0]        wdat;
    logic [N-1:0]        clr_vec;
    logic [N-1:0]        set_vec;
    logic                unused_wdata_hi;

    assign idx             = bus_addr[AW-1:2];
    assign aligned         = (bus_addr[1:0] == 2'b00);
    assign wdat            = bus_wdata[N-1:0];
    assign unused_wdata_hi = ^bus_wdata[DW-1:N];

    // One write strobe per register
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_wsel
        assign wsel[r] = bus_wr && aligned && (idx == IDX_W'(r));
    end

    assign clr_vec = wsel[REG_PEND]   ? wdat : '0;
    assign set_vec = wsel[REG_SWTRIG] ? wdat : '0;

    // Configuration registers, plain write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask    <= '0;
            emask    <= '0;
            rise_sel <= '0;
            fall_sel <= '0;
        end else begin
            if (wsel[REG_IMASK]) imask    <= wdat;
            if (wsel[REG_EMASK]) emask    <= wdat;
            if (wsel[REG_RISE])  rise_sel <= wdat;
            if (wsel[REG_FALL])  fall_sel <= wdat;
        end
    end

    // Pending: clear first, then edges and software sets win
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | edge_hit | set_vec;
    end

    // Software trigger bits follow the clear of their pending bit
    always_ff @(posedge clk) begin
        if (!rst_n) sw_bits <= '0;
        else        sw_bits <= (sw_bits & ~clr_vec) | set_vec;
    end

    // Event strobe, one cycle per qualified edge
    always_ff @(posedge clk) begin
        if (!rst_n) evt_out <= '0;
        else        evt_out <= edge_hit & emask;
    end

    // Read mux, zero for unmapped, misaligned or idle
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && aligned) begin
            case (idx)
                IDX_W'(REG_IMASK):  bus_rdata[N-1:0] = imask;
                IDX_W'(REG_EMASK):  bus_rdata[N-1:0] = emask;
                IDX_W'(REG_RISE):   bus_rdata[N-1:0] = rise_sel;
                IDX_W'(REG_FALL):   bus_rdata[N-1:0] = fall_sel;
                IDX_W'(REG_SWTRIG): bus_rdata[N-1:0] = sw_bits;
                IDX_W'(REG_PEND):   bus_rdata[N-1:0] = pend;
                default:            bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/edge_irq_route.sv
// Module: edge_irq_route
// Folds masked pending bits onto the interrupt outputs using the fixed
// grouping from the package; lines mapped to -1 drive nothing.
// Assumes: NI matches the number of distinct outputs in the grouping.
module edge_irq_route
    import edge_irq_pkg::*;
#(
    parameter int N  = NUM_LINES,
    parameter int NI = NUM_IRQ
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  imask,
    output logic [NI-1:0] irq_out
);

    for (genvar g = 0; g < NI; g++) begin : g_irq
        logic acc;
        // OR of every unmasked pending line grouped onto output g
        always_comb begin
            acc = 1'b0;
            for (int l = 0; l < N; l++) begin
                if (irq_of_line(l) == g) acc = acc | (pend[l] & imask[l]);
            end
        end
        assign irq_out[g] = acc;
    end

endmodule

// File: rtl/edge_irq_ctrl.sv
// Module: edge_irq_ctrl (top)
// External edge interrupt controller: synchroniser and edge detector,
// register file with sticky pending, and grouped interrupt outputs.
// Assumes: one clock domain for the bus; ext_in may be fully asynchronous.
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES_P = NUM_LINES,
    parameter int NUM_IRQ_P   = NUM_IRQ,
    parameter int DATA_W_P    = DATA_W,
    parameter int ADDR_W_P    = ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES_P-1:0] ext_in,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W_P-1:0]    bus_addr,
    input  logic [DATA_W_P-1:0]    bus_wdata,
    output logic [DATA_W_P-1:0]    bus_rdata,
    output logic [NUM_IRQ_P-1:0]   irq_out,
    output logic [NUM_LINES_P-1:0] evt_out
);

    logic [NUM_LINES_P-1:0] edge_hit;
    logic [NUM_LINES_P-1:0] imask_q;
    logic [NUM_LINES_P-1:0] emask_q;
    logic [NUM_LINES_P-1:0] rise_q;
    logic [NUM_LINES_P-1:0] fall_q;
    logic [NUM_LINES_P-1:0] sw_q;
    logic [NUM_LINES_P-1:0] pend_q;

    edge_irq_sync #(.N(NUM_LINES_P)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_in),
        .rise_sel (rise_q),
        .fall_sel (fall_q),
        .edge_hit (edge_hit)
    );

    edge_irq_regs #(.N(NUM_LINES_P), .DW(DATA_W_P), .AW(ADDR_W_P)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .edge_hit  (edge_hit),
        .imask     (imask_q),
        .emask     (emask_q),
        .rise_sel  (rise_q),
        .fall_sel  (fall_q),
        .sw_bits   (sw_q),
        .pend      (pend_q),
        .evt_out   (evt_out)
    );

    edge_irq_route #(.N(NUM_LINES_P), .NI(NUM_IRQ_P)) u_route (
        .pend    (pend_q),
        .imask   (imask_q),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/edge_irq_ctrl_chk.sv
// Module: edge_irq_ctrl_chk
// Concurrent checks on the controller, attached to every instance of the
// top module by the bind statement at the end of this file.
// Assumes: the top's internal vectors keep the names used in the bind.
module edge_irq_ctrl_chk #(
    parameter int N  = 23,
    parameter int NI = 12,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [N-1:0]  bus_wdata,
    input logic [N-1:0]  edge_hit,
    input logic [N-1:0]  pend,
    input logic [N-1:0]  sw_bits,
    input logic [N-1:0]  imask,
    input logic [N-1:0]  emask,
    input logic [NI-1:0] irq_out,
    input logic [N-1:0]  evt_out
);

    localparam logic [AW-1:0] PEND_OFS = AW'(5 * 4);

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((pend & $past(edge_hit)) == $past(edge_hit))); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PEND_OFS) |=> ((pend & $past(bus_wdata & ~edge_hit)) == '0)); // R5

    AST_SW_WITHIN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_bits & ~pend) == '0)); // R7

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & imask) == '0) |-> (irq_out == '0)); // R8

    AST_EVT_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_out & ~$past(edge_hit & emask)) == '0)); // R11

endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.N(NUM_LINES_P), .NI(NUM_IRQ_P), .AW(ADDR_W_P)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata[NUM_LINES_P-1:0]),
    .edge_hit  (edge_hit),
    .pend      (pend_q),
    .sw_bits   (sw_q),
    .imask     (imask_q),
    .emask     (emask_q),
    .irq_out   (irq_out),
    .evt_out   (evt_out)
);

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
// Bench: behavioural per-clock reference model plus directed register reads.
module edge_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [22:0] ext_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire  [11:0] irq_out;
    wire  [22:0] evt_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    localparam logic [22:0] ALL = 23'h7FFFFF;

    edge_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .evt_out(evt_out)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [22:0] m_s1, m_s2, m_prev, m_imask, m_emask, m_rise, m_fall, m_sw, m_pend, m_evt;

    function automatic logic [11:0] exp_irq(input logic [22:0] act);
        logic [11:0] r = '0;
        for (int i = 0; i < 23; i++) begin
            if (act[i]) begin
                if (i < 5)                         r[i] = 1'b1;
                else if (i < 10)                   r[5] = 1'b1;
                else if (i < 16)                   r[6] = 1'b1;
                else if (i == 16 || i == 17 || i == 18) r[i-9] = 1'b1;
                else if (i == 21)                  r[10] = 1'b1;
                else if (i == 22)                  r[11] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h00: return {9'd0, m_imask};
            5'h04: return {9'd0, m_emask};
            5'h08: return {9'd0, m_rise};
            5'h0C: return {9'd0, m_fall};
            5'h10: return {9'd0, m_sw};
            5'h14: return {9'd0, m_pend};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [22:0] hit, clr, set;
        cyc++;
        if (!rst_n) begin
            {m_s1, m_s2, m_prev, m_imask, m_emask} = '0;
            {m_rise, m_fall, m_sw, m_pend, m_evt} = '0;
        end else begin
            hit = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
            clr = (bus_wr && bus_addr == 5'h14) ? bus_wdata[22:0] : '0;
            set = (bus_wr && bus_addr == 5'h10) ? bus_wdata[22:0] : '0;
            m_evt  = hit & m_emask;
            m_pend = (m_pend & ~clr) | hit | set;
            m_sw   = (m_sw & ~clr) | set;
            if (bus_wr && bus_addr == 5'h00) m_imask = bus_wdata[22:0];
            if (bus_wr && bus_addr == 5'h04) m_emask = bus_wdata[22:0];
            if (bus_wr && bus_addr == 5'h08) m_rise  = bus_wdata[22:0];
            if (bus_wr && bus_addr == 5'h0C) m_fall  = bus_wdata[22:0];
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = ext_in;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            chk("R9 irq_out vs model", {20'd0, irq_out}, {20'd0, exp_irq(m_pend & m_imask)});
            chk("R11 evt_out vs model", {9'd0, evt_out}, {9'd0, m_evt});
            chk("R2 rdata vs model", bus_rdata, bus_rd ? exp_rd(bus_addr) : 32'd0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        #1 chk(tag, bus_rdata, e);
    endtask

    task automatic setx(input int ln, input logic v);
        @(negedge clk); #1;
        ext_in[ln] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3); #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) rd(5'(a * 4), 32'd0, "R1 register after reset");
        chk("R1 irq_out after reset", {20'd0, irq_out}, 32'd0);
        chk("R1 evt_out after reset", {9'd0, evt_out}, 32'd0);

        // R2 map, unused bits and unmapped address
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, 32'h007F_FFFF, "R2 mask upper bits read zero");
        rd(5'h18, 32'd0, "R2 unmapped address");
        rd(5'h02, 32'd0, "R2 misaligned address");

        // R3 latency, rising on line 3
        wr(5'h08, 32'h0000_0008);
        setx(3, 1'b1);
        rd(5'h14, 32'd0, "R3 pending one edge after change");
        rd(5'h14, 32'd0, "R3 pending two edges after change");
        rd(5'h14, 32'h8, "R3 pending three edges after change");
        chk("R9 line 3 own output", {20'd0, irq_out}, 32'h008);

        // R4 unselected falling edge ignored
        setx(3, 1'b0);
        idle(4);
        rd(5'h14, 32'h8, "R4 falling not selected");

        // R8 mask gates output, not pending
        wr(5'h00, {9'd0, ALL & ~23'h8});
        rd(5'h14, 32'h8, "R8 pending kept while masked");
        chk("R8 output low while masked", {20'd0, irq_out}, 32'd0);
        wr(5'h00, {9'd0, ALL});
        rd(5'h00, {9'd0, ALL}, "R8 mask restored");
        chk("R8 output high when unmasked", {20'd0, irq_out}, 32'h008);

        // R5 write one to clear
        wr(5'h14, 32'd0);
        rd(5'h14, 32'h8, "R5 zero write leaves pending");
        wr(5'h14, 32'h8);
        rd(5'h14, 32'd0, "R5 one clears pending");

        // R4 both edges on line 7
        wr(5'h08, 32'h80);
        wr(5'h0C, 32'h80);
        setx(7, 1'b1);
        idle(4);
        rd(5'h14, 32'h80, "R4 rising with both selected");
        chk("R9 line 7 on shared output", {20'd0, irq_out}, 32'h020);
        wr(5'h14, 32'h80);
        setx(7, 1'b0);
        idle(4);
        rd(5'h14, 32'h80, "R4 falling with both selected");
        wr(5'h14, 32'h80);

        // R9 more grouping
        wr(5'h08, {9'd0, ALL});
        @(negedge clk); #1 ext_in = ext_in | 23'h401000;
        idle(4);
        rd(5'h14, 32'h0040_1000, "R9 lines 12 and 22 pending");
        chk("R9 lines 12 and 22 outputs", {20'd0, irq_out}, 32'h840);
        wr(5'h14, {9'd0, ALL});
        rd(5'h14, 32'd0, "R5 clear all");

        // R6 edge and clear in the same cycle
        setx(12, 1'b0);
        idle(3);
        setx(12, 1'b1);
        @(negedge clk);
        wr(5'h14, 32'h1000);
        rd(5'h14, 32'h1000, "R6 edge wins over clear");
        wr(5'h14, 32'h1000);
        rd(5'h14, 32'd0, "R6 later clear works");

        // R7 software trigger
        wr(5'h10, 32'h3);
        rd(5'h10, 32'h3, "R7 trigger bits set");
        rd(5'h14, 32'h3, "R7 trigger sets pending");
        chk("R7 trigger raises outputs", {20'd0, irq_out}, 32'h003);
        wr(5'h10, 32'd0);
        rd(5'h10, 32'h3, "R7 zero write no effect");
        wr(5'h14, 32'h1);
        rd(5'h14, 32'h2, "R7 pending after one clear");
        rd(5'h10, 32'h2, "R7 trigger bit follows clear");
        wr(5'h14, 32'h2);

        // R10 lines 19 and 20 have no output
        @(negedge clk); #1 ext_in = ext_in | 23'h180000;
        idle(4);
        rd(5'h14, 32'h0018_0000, "R10 lines 19 20 pending");
        chk("R10 no output from 19 20", {20'd0, irq_out}, 32'd0);
        wr(5'h14, {9'd0, ALL});

        // R11 event pulse
        wr(5'h04, 32'h2);
        setx(1, 1'b1);
        idle(2);
        @(negedge clk); #1 chk("R11 event pulse high", {9'd0, evt_out}, 32'h2);
        @(negedge clk); #1 chk("R11 event pulse one cycle", {9'd0, evt_out}, 32'h0);
        rd(5'h14, 32'h2, "R11 edge also pends");
        wr(5'h14, 32'h2);
        wr(5'h04, 32'h0);
        setx(1, 1'b0);
        idle(3);
        setx(1, 1'b1);
        idle(2);
        @(negedge clk); #1 chk("R11 no pulse when event masked", {9'd0, evt_out}, 32'h0);
        rd(5'h14, 32'h2, "R11 event mask does not gate pending");

        idle(3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule